// File: doc/BRIEF.md
# Single-Bit Chunk ECC Checker

This block decides whether a 512-byte flash chunk read back from the array matches the 24-bit single-error-correcting code stored with it. Another unit accumulates the column and row parity of the chunk into a 32-bit register value, and this block receives that value. It builds the calculated code from two 12-bit fields of that value and inverts it, so that an erased chunk (all ones, with an all-ones stored code) checks clean. It then compares the calculated code with the stored code and classifies the difference.

A correctable data error yields the byte offset inside the chunk and the bit number in that byte. The software or buffer logic around the block flips that bit. A single-bit difference means the stored code itself was hit, and the data is left alone. The packed, inverted code is also presented, which is the value to write to the spare area on the programming path. The block takes one request per `start` strobe. A request is accepted on every cycle that `start` is high, with no back-pressure. Each accepted request produces exactly one `done` pulse one clock later. The result then stays on the outputs until the next request.

Top module: `ecc1_chunk_check`

## Requirements
- R1: `calc_code` equals the bitwise inverse of {raw[27:16], raw[11:0]}. Byte 0 of the code is `calc_code[7:0]` and byte 2 is `calc_code[23:16]`. `stored_code` uses the same byte order.
- R2: A raw value of zero together with a stored code of 24'hFFFFFF (an erased chunk) reports status 0 (clean).
- R3: When the difference `calc_code ^ stored_code` is zero, status is 0 (clean).
- R4: When the upper 12 bits of the difference XOR the lower 12 bits equal 12'hFFF and the byte index is in range, status is 1 (data corrected). `err_byte` is then difference bits [23:15] and `err_bit` is difference bits [14:12].
- R5: A difference that passes the R4 pattern test with a byte index not below the `CHUNK_BYTES` parameter reports status 3 (uncorrectable).
- R6: A difference with exactly one bit set reports status 2 (stored code error only), and no data location is given.
- R7: Any other non-zero difference reports status 3 (uncorrectable).
- R8: `done` is high for exactly the one cycle after each cycle with `start` high. All result outputs are registered and hold their values while `start` is low.
- R9: After reset, `done`, `status`, `err_byte`, `err_bit` and `calc_code` are all zero.
- R10: `err_byte` and `err_bit` are zero whenever status is not 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe; inputs are sampled on this cycle |
| raw_par | input | 32 | Raw parity register value for the chunk |
| stored_code | input | 24 | Code read from the spare area, byte 0 in bits [7:0] |
| done | output | 1 | One-cycle result pulse |
| status | output | 2 | 0 clean, 1 data corrected, 2 code-only error, 3 uncorrectable |
| err_byte | output | 9 | Byte offset to fix when status is 1 |
| err_bit | output | 3 | Bit number to fix when status is 1 |
| calc_code | output | 24 | Packed, inverted calculated code |

## Verification
Some properties are checked on every cycle: the timing of `done` against `start`, the holding of results between requests, the packing and inversion of `calc_code` against the previous raw value, the agreement between a clean status and a zero difference, and the zeroing of the location outputs outside status 1. The rest of the classification can only be shown by the bench's scenarios. These are the complement-halves pattern with its range check on a reduced chunk size, the single-bit code fault, the erased chunk and arbitrary multi-bit differences.

// File: rtl/ecc1_pkg.sv
package ecc1_pkg;
  typedef enum logic [1:0] {
    ST_CLEAN     = 2'd0,
    ST_FIX_DATA  = 2'd1,
    ST_CODE_ONLY = 2'd2,
    ST_UNCORR    = 2'd3
  } ecc_status_e;
endpackage

// File: rtl/ecc1_packer.sv
module ecc1_packer #(
  parameter int RAW_W  = 32,
  parameter int HALF_W = 12,
  parameter int HI_OFS = 16
) (
  input  logic [RAW_W-1:0]    raw,
  output logic [2*HALF_W-1:0] code
);
  // R1: two parity fields joined, then inverted so erased data checks clean
  always_comb begin
    code = ~{raw[HI_OFS +: HALF_W], raw[HALF_W-1:0]};
  end
endmodule

// File: rtl/ecc1_classify.sv
module ecc1_classify
  import ecc1_pkg::*;
#(
  parameter int HALF_W      = 12,
  parameter int BIT_W       = 3,
  parameter int CHUNK_BYTES = 512,
  localparam int CODE_W     = 2 * HALF_W,
  localparam int BYTE_W     = CODE_W - HALF_W - BIT_W
) (
  input  logic [CODE_W-1:0] diff,
  output ecc_status_e       kind,
  output logic [BYTE_W-1:0] loc_byte,
  output logic [BIT_W-1:0]  loc_bit
);
  logic [HALF_W-1:0] fold;
  logic              compl_ok;
  logic              single;
  logic [BYTE_W-1:0] idx;
  logic [BIT_W-1:0]  bno;
  logic              in_range;

  always_comb begin
    fold     = diff[CODE_W-1:HALF_W] ^ diff[HALF_W-1:0];
    compl_ok = (fold == {HALF_W{1'b1}});
    single   = (diff != '0) && ((diff & (diff - 1'b1)) == '0);
    idx      = diff[CODE_W-1 -: BYTE_W];
    bno      = diff[HALF_W +: BIT_W];
    in_range = ({1'b0, idx} < (BYTE_W+1)'(CHUNK_BYTES));

    kind     = ST_UNCORR;
    loc_byte = '0;
    loc_bit  = '0;
    if (diff == '0) begin
      kind = ST_CLEAN;
    end else if (compl_ok) begin
      if (in_range) begin
        kind     = ST_FIX_DATA;
        loc_byte = idx;
        loc_bit  = bno;
      end
    end else if (single) begin
      kind = ST_CODE_ONLY;
    end
  end
endmodule

// File: rtl/ecc1_chunk_check.sv
module ecc1_chunk_check
  import ecc1_pkg::*;
#(
  parameter int RAW_W       = 32,
  parameter int HALF_W      = 12,
  parameter int HI_OFS      = 16,
  parameter int BIT_W       = 3,
  parameter int CHUNK_BYTES = 512,
  localparam int CODE_W     = 2 * HALF_W,
  localparam int BYTE_W     = CODE_W - HALF_W - BIT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [RAW_W-1:0]  raw_par,
  input  logic [CODE_W-1:0] stored_code,
  output logic              done,
  output logic [1:0]        status,
  output logic [BYTE_W-1:0] err_byte,
  output logic [BIT_W-1:0]  err_bit,
  output logic [CODE_W-1:0] calc_code
);
  logic [CODE_W-1:0] code_c;
  logic [CODE_W-1:0] diff_c;
  ecc_status_e       kind_c;
  logic [BYTE_W-1:0] byte_c;
  logic [BIT_W-1:0]  bit_c;

  ecc1_packer #(.RAW_W(RAW_W), .HALF_W(HALF_W), .HI_OFS(HI_OFS)) u_pack (
    .raw  (raw_par),
    .code (code_c)
  );

  assign diff_c = code_c ^ stored_code;

  ecc1_classify #(.HALF_W(HALF_W), .BIT_W(BIT_W), .CHUNK_BYTES(CHUNK_BYTES)) u_cls (
    .diff     (diff_c),
    .kind     (kind_c),
    .loc_byte (byte_c),
    .loc_bit  (bit_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      status    <= 2'd0;
      err_byte  <= '0;
      err_bit   <= '0;
      calc_code <= '0;
    end else begin
      done <= start;
      if (start) begin
        status    <= kind_c;
        err_byte  <= byte_c;
        err_bit   <= bit_c;
        calc_code <= code_c;
      end
    end
  end
endmodule

// File: rtl/ecc1_check_sva.sv
module ecc1_check_sva #(
  parameter int RAW_W  = 32,
  parameter int HALF_W = 12,
  parameter int HI_OFS = 16,
  parameter int BIT_W  = 3,
  localparam int CODE_W = 2 * HALF_W,
  localparam int BYTE_W = CODE_W - HALF_W - BIT_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [RAW_W-1:0]  raw_par,
  input logic [CODE_W-1:0] stored_code,
  input logic              done,
  input logic [1:0]        status,
  input logic [BYTE_W-1:0] err_byte,
  input logic [BIT_W-1:0]  err_bit,
  input logic [CODE_W-1:0] calc_code
);
  p_done_after_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(status) && $stable(err_byte) && $stable(calc_code)));
  p_pack_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (calc_code == ~{$past(raw_par[HI_OFS +: HALF_W]), $past(raw_par[HALF_W-1:0])}));
  p_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ((status == 2'd0) == ((calc_code ^ $past(stored_code)) == '0)));
  p_loc_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (status != 2'd1) |-> (err_byte == '0 && err_bit == '0));
endmodule

bind ecc1_chunk_check ecc1_check_sva #(
  .RAW_W(RAW_W), .HALF_W(HALF_W), .HI_OFS(HI_OFS), .BIT_W(BIT_W)
) u_sva (
  .clk(clk), .rst_n(rst_n), .start(start), .raw_par(raw_par),
  .stored_code(stored_code), .done(done), .status(status),
  .err_byte(err_byte), .err_bit(err_bit), .calc_code(calc_code)
);

// File: tb/test_ecc1_chunk_check.sv
module test_ecc1_chunk_check;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] raw_par = '0;
  logic [23:0] stored_code = '0;
  logic        done, done_s;
  logic [1:0]  status, status_s;
  logic [8:0]  err_byte, err_byte_s;
  logic [2:0]  err_bit, err_bit_s;
  logic [23:0] calc_code, calc_code_s;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ecc1_chunk_check i_ecc1_chunk_check (
    .clk(clk), .rst_n(rst_n), .start(start), .raw_par(raw_par),
    .stored_code(stored_code), .done(done), .status(status),
    .err_byte(err_byte), .err_bit(err_bit), .calc_code(calc_code)
  );

  ecc1_chunk_check #(.CHUNK_BYTES(256)) i_ecc1_chunk_check_small (
    .clk(clk), .rst_n(rst_n), .start(start), .raw_par(raw_par),
    .stored_code(stored_code), .done(done_s), .status(status_s),
    .err_byte(err_byte_s), .err_bit(err_bit_s), .calc_code(calc_code_s)
  );

  function automatic logic [23:0] m_code(input logic [31:0] r);
    return ~{r[27:16], r[11:0]};
  endfunction

  function automatic logic [1:0] m_status(input logic [23:0] d, input int chunk);
    if (d == 0) return 2'd0;
    if ((d[23:12] ^ d[11:0]) == 12'hFFF) return (int'(d[23:15]) < chunk) ? 2'd1 : 2'd3;
    if ($countones(d) == 1) return 2'd2;
    return 2'd3;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] r, input logic [23:0] s, input string tag);
    logic [23:0] d;
    logic [1:0]  e1, e2;
    d  = m_code(r) ^ s;
    e1 = m_status(d, 512);
    e2 = m_status(d, 256);
    @(negedge clk);
    raw_par = r; stored_code = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    raw_par = ~r; stored_code = ~s;
    chk({"R8 done ", tag}, 32'(done), 32'd1);
    chk({"R1 code ", tag}, 32'(calc_code), 32'(m_code(r)));
    chk({"R3-R7 status ", tag}, 32'(status), 32'(e1));
    chk({"R5 small status ", tag}, 32'(status_s), 32'(e2));
    chk({"R4 R10 byte ", tag}, 32'(err_byte), (e1 == 2'd1) ? 32'(d[23:15]) : 32'd0);
    chk({"R4 R10 bit ", tag}, 32'(err_bit), (e1 == 2'd1) ? 32'(d[14:12]) : 32'd0);
    @(negedge clk);
    chk({"R8 single pulse ", tag}, 32'(done), 32'd0);
    chk({"R8 hold ", tag}, 32'(status), 32'(e1));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [11:0] lo;
    void'($urandom(32'd7531));
    repeat (3) @(negedge clk);
    chk("R9 done", 32'(done), 0);
    chk("R9 status", 32'(status), 0);
    chk("R9 loc", {20'd0, err_byte, err_bit}, 0);
    chk("R9 code", 32'(calc_code), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 erased chunk
    run(32'h0, 24'hFFFFFF, "R2 erased");
    // R3 match
    run(32'h0ABC_0123, m_code(32'h0ABC_0123), "R3 match");
    // R4 largest index, small chunk sees R5
    run(32'h0, 24'hFFFFFF ^ {12'hFFF, 12'h000}, "R4 R5 idx511");
    run(32'h0, 24'hFFFFFF ^ {12'h000, 12'hFFF}, "R4 idx0");
    run(32'h0, 24'hFFFFFF ^ {12'h800, 12'h7FF}, "R5 idx256");
    // R6 single bit faults
    run(32'h1234_5678, m_code(32'h1234_5678) ^ 24'h000001, "R6 lsb");
    run(32'h1234_5678, m_code(32'h1234_5678) ^ 24'h800000, "R6 msb");
    // R7 two bits
    run(32'h0, 24'hFFFFFF ^ 24'h000003, "R7 twobit");
    for (int i = 0; i < 400; i++) begin
      r  = $urandom;
      lo = 12'($urandom);
      case ($urandom % 4)
        0: run(r, m_code(r), "rand clean");
        1: run(r, m_code(r) ^ {~lo, lo}, "rand fix");
        2: run(r, m_code(r) ^ (24'd1 << ($urandom % 24)), "rand one");
        default: run(r, 24'($urandom), "rand any");
      endcase
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule